// File: doc/BRIEF.md
# Watchdog Timer with Reset Steering

This block supervises a processor by counting ticks of a 16 Hz timebase that is generated elsewhere. Software programs an 8-bit configuration register with three fields. A steering bit chooses the action on expiry. A 5-bit multiplier and a 2-bit resolution code together set the timeout. The countdown starts over on any change of level on an external kick pin, and on any write to the register.

When the count expires without a restart, the block sets a watchdog flag, which a read of the flags register clears. The steering bit then picks one of two outcomes:

- **Interrupt:** the block raises an interrupt request. The request stays high until software writes zero to the register.
- **Reset:** the block drives an active-low reset pulse of fixed length. It also wipes the register and sends a one-cycle strobe to clear a frequency-test bit held in another block.

A power-down indication disables the block and clears the register.

Top module: `watchdog_steer`

## Requirements
- R1: The timeout is the multiplier (bits 6..2) times a resolution (bits 1..0) in ticks: code 00 = 1 tick, 01 = 4, 10 = 16 and 11 = 64 ticks. The flag rises on the tick that completes that count after the last restart.
- R2: A multiplier of zero disables the watchdog, and no tick count makes it expire.
- R3: A rising or a falling edge on `kickIn` restarts the count. The edge passes through two synchroniser flip-flops and an edge detector, so it acts at the third rising clock edge after the pin changes.
- R4: Any register write restarts the count and loads the register. A write in the same cycle as a tick suppresses that tick's expiry.
- R5: Expiry sets `wdFlag`, and a one-cycle `flagRdEn` clears it. When both happen in the same cycle, the set wins.
- R6: With bit 7 = 0, expiry sets `irqOut`. It stays high until a write of 00h or `pwrDown` clears it, and a write of any nonzero value leaves it set.
- R7: With bit 7 = 1, expiry drives `rstOutN` low and leaves `irqOut` low. The pulse lasts `RST_TICKS` ticks (default 2, or 125 ms) and ends on the second tick after expiry.
- R8: With bit 7 = 1, the register reads 00h after expiry and `ftClrStb` pulses high for exactly one cycle. No further expiry follows until the register is reprogrammed.
- R9: While `pwrDown` is high, the register is 00h, `irqOut` is low and writes are ignored.
- R10: After reset, `cfgOut` = 00h, `wdFlag` = 0, `irqOut` = 0, `rstOutN` = 1 and `ftClrStb` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle strobe at 16 Hz |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write value |
| kickIn | input | 1 | Asynchronous kick pin, either edge restarts |
| flagRdEn | input | 1 | Flags-register read strobe |
| pwrDown | input | 1 | Power-down indication |
| cfgOut | output | 8 | Current register value |
| wdFlag | output | 1 | Watchdog expiry flag |
| irqOut | output | 1 | Interrupt request, active high |
| rstOutN | output | 1 | Reset pulse, active low |
| ftClrStb | output | 1 | One-cycle strobe that clears the frequency-test bit |

## Verification
The bench builds the block with its default parameters: two synchroniser stages and a two-tick reset pulse. With these values the kick latency is a fixed three edges and the end of the reset pulse falls on a known tick. Because the tick strobe is driven directly by the bench, the longest timeout (multiplier 31 at the 64-tick resolution, 1984 ticks) can be walked to within one tick of expiry. The tests also cover every resolution code, both steering outcomes and the tick-and-write collision.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic restart;
    logic loadCfg;
    logic wipeCfg;
    logic timeout;
    logic setIrq;
    logic startPulse;
    logic clrFlag;
    logic clrIrq;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             kickIn,
  input  logic             regWrEn,
  input  logic [CFG_W-1:0] regWrData,
  input  logic             flagRdEn,
  input  logic             pwrDown,
  input  logic             expireHit,
  input  logic             cfgSteer,
  output wdStrobe_t        strb
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic kickPrev;
  logic kickEdge;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= kickIn;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], kickIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) kickPrev <= 1'b0;
    else       kickPrev <= syncQ[SYNC_STAGES-1];
  end

  assign kickEdge = syncQ[SYNC_STAGES-1] ^ kickPrev;

  always_comb begin
    strb            = '0;
    strb.restart    = regWrEn | kickEdge | pwrDown;
    strb.loadCfg    = regWrEn & ~pwrDown;
    strb.timeout    = expireHit & ~strb.restart;
    strb.setIrq     = strb.timeout & ~cfgSteer;
    strb.startPulse = strb.timeout & cfgSteer;
    strb.wipeCfg    = pwrDown | strb.startPulse;
    strb.clrFlag    = flagRdEn;
    strb.clrIrq     = pwrDown | (regWrEn & (regWrData == '0));
  end
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int MULT_W = 5,
  parameter int RES_W = 2,
  parameter int RST_TICKS = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        tick16,
  input  logic [MULT_W+RES_W:0]       wrData,
  input  wdStrobe_t                   strb,
  output logic                        expireHit,
  output logic                        cfgSteer,
  output logic [MULT_W+RES_W:0]       cfgQ,
  output logic                        flagQ,
  output logic                        irqQ,
  output logic                        rstLowQ,
  output logic                        ftClrQ
);
  localparam int CFG_W = MULT_W + RES_W + 1;
  localparam int NRES  = 2 ** RES_W;
  localparam int CNT_W = MULT_W + 2 * (NRES - 1);
  localparam int PC_W  = $clog2(RST_TICKS + 1);

  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  res;
  logic [CNT_W-1:0]  limitOpt [NRES];
  logic [CNT_W-1:0]  limit;
  logic [CNT_W-1:0]  cnt;
  logic [PC_W-1:0]   pcnt;
  logic              expired;
  logic              armed;

  assign mult     = cfgQ[CFG_W-2:RES_W];
  assign res      = cfgQ[RES_W-1:0];
  assign cfgSteer = cfgQ[CFG_W-1];

  genvar g;
  generate
    for (g = 0; g < NRES; g++) begin : g_res
      assign limitOpt[g] = CNT_W'(mult) << (2 * g);
    end
  endgenerate

  assign limit     = limitOpt[res];
  assign armed     = (mult != '0) & ~expired;
  assign expireHit = tick16 & armed & (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)             cfgQ <= '0;
    else if (strb.wipeCfg) cfgQ <= '0;
    else if (strb.loadCfg) cfgQ <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (strb.restart) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (strb.timeout) begin
      cnt     <= '0;
      expired <= 1'b1;
    end else if (tick16 && armed) begin
      cnt     <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             flagQ <= 1'b0;
    else if (strb.timeout) flagQ <= 1'b1;
    else if (strb.clrFlag) flagQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            irqQ <= 1'b0;
    else if (strb.setIrq) irqQ <= 1'b1;
    else if (strb.clrIrq) irqQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstLowQ <= 1'b0;
      pcnt    <= '0;
    end else if (strb.startPulse) begin
      rstLowQ <= 1'b1;
      pcnt    <= '0;
    end else if (rstLowQ && tick16) begin
      if (pcnt == PC_W'(RST_TICKS - 1)) rstLowQ <= 1'b0;
      else                              pcnt    <= pcnt + PC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ftClrQ <= 1'b0;
    else       ftClrQ <= strb.startPulse;
  end
endmodule

// File: rtl/watchdog_steer.sv
module watchdog_steer
  import wdog_pkg::*;
#(
  parameter int MULT_W = 5,
  parameter int RES_W = 2,
  parameter int RST_TICKS = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CFG_W = MULT_W + RES_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick16,
  input  logic             regWrEn,
  input  logic [CFG_W-1:0] regWrData,
  input  logic             kickIn,
  input  logic             flagRdEn,
  input  logic             pwrDown,
  output logic [CFG_W-1:0] cfgOut,
  output logic             wdFlag,
  output logic             irqOut,
  output logic             rstOutN,
  output logic             ftClrStb
);
  wdStrobe_t strb;
  logic expireHit;
  logic cfgSteer;
  logic rstLow;

  wdog_ctrl #(.SYNC_STAGES(SYNC_STAGES), .CFG_W(CFG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .kickIn(kickIn), .regWrEn(regWrEn),
    .regWrData(regWrData), .flagRdEn(flagRdEn), .pwrDown(pwrDown),
    .expireHit(expireHit), .cfgSteer(cfgSteer), .strb(strb)
  );

  wdog_dp #(.MULT_W(MULT_W), .RES_W(RES_W), .RST_TICKS(RST_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .tick16(tick16), .wrData(regWrData),
    .strb(strb), .expireHit(expireHit), .cfgSteer(cfgSteer),
    .cfgQ(cfgOut), .flagQ(wdFlag), .irqQ(irqOut), .rstLowQ(rstLow),
    .ftClrQ(ftClrStb)
  );

  assign rstOutN = ~rstLow;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick16,
  input logic             regWrEn,
  input logic [CFG_W-1:0] regWrData,
  input logic             pwrDown,
  input logic [CFG_W-1:0] cfgOut,
  input logic             wdFlag,
  input logic             irqOut,
  input logic             rstOutN,
  input logic             ftClrStb
);
  // R1
  flag_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdFlag) |-> $past(tick16));

  // R2
  mult_zero_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOut[CFG_W-2:2] == '0) |=> !$rose(wdFlag));

  // R6
  irq_clear_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> ($past(pwrDown) || ($past(regWrEn) && $past(regWrData) == '0)));

  // R7
  pulse_steer_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstOutN) |-> ($past(cfgOut[CFG_W-1]) && $past(tick16) && $rose(wdFlag)));

  // R8
  ft_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ftClrStb |-> (cfgOut == '0) && !rstOutN);

  // R8
  ft_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ftClrStb |=> !ftClrStb);

  // R9
  pwr_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |=> (cfgOut == '0) && !irqOut);
endmodule

bind watchdog_steer wdog_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick16(tick16), .regWrEn(regWrEn),
  .regWrData(regWrData), .pwrDown(pwrDown), .cfgOut(cfgOut),
  .wdFlag(wdFlag), .irqOut(irqOut), .rstOutN(rstOutN), .ftClrStb(ftClrStb)
);

// File: tb/tb_watchdog_steer.sv
module tb_watchdog_steer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic kickIn = 1'b0;
  logic flagRdEn = 1'b0;
  logic pwrDown = 1'b0;
  logic [7:0] cfgOut;
  logic wdFlag, irqOut, rstOutN, ftClrStb;

  int nChecks = 0;
  int nFails = 0;
  int ftSeen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  watchdog_steer dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .regWrEn(regWrEn),
    .regWrData(regWrData), .kickIn(kickIn), .flagRdEn(flagRdEn),
    .pwrDown(pwrDown), .cfgOut(cfgOut), .wdFlag(wdFlag), .irqOut(irqOut),
    .rstOutN(rstOutN), .ftClrStb(ftClrStb)
  );

  always @(negedge clk) if (ftClrStb) ftSeen++;

  // [31:24] cfg, [23:8] ticks, [2] flag, [1] irq, [0] reset low
  localparam logic [31:0] VEC [9] = '{
    {8'h04, 16'd1,    8'h06},  // R1 mult1 res00
    {8'h04, 16'd0,    8'h00},  // R1 before first tick
    {8'h0E, 16'd47,   8'h00},  // R1 3 x 16 minus one
    {8'h0E, 16'd48,   8'h06},  // R1 3 x 16
    {8'h85, 16'd4,    8'h05},  // R7 steer1 1 x 4
    {8'h85, 16'd3,    8'h00},  // R7 one short
    {8'h7F, 16'd1983, 8'h00},  // R1 31 x 64 minus one
    {8'h7F, 16'd1984, 8'h06},  // R1 31 x 64
    {8'h03, 16'd200,  8'h00}   // R2 mult zero
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doTick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick16 = 1'b1;
      @(negedge clk) tick16 = 1'b0;
    end
  endtask

  task automatic doWrite(input logic [7:0] v);
    @(negedge clk) begin regWrEn = 1'b1; regWrData = v; end
    @(negedge clk) regWrEn = 1'b0;
  endtask

  task automatic doRead();
    @(negedge clk) flagRdEn = 1'b1;
    @(negedge clk) flagRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic prep();
    doRead();
    doWrite(8'h00);
    doTick(3);
    doRead();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10
    chk("R10 reset state", {cfgOut, wdFlag, irqOut, rstOutN, ftClrStb}, {8'h00, 4'b0010});

    for (int v = 0; v < 9; v++) begin
      prep();
      doWrite(VEC[v][31:24]);
      doTick(int'(VEC[v][23:8]));
      chk($sformatf("R1/R2/R7 vector %0d", v), {wdFlag, irqOut, ~rstOutN}, VEC[v][2:0]);
    end

    // R3 rising edge restart
    prep();
    doWrite(8'h08);
    doTick(1);
    @(negedge clk) kickIn = 1'b1;
    idle(4);
    doTick(1);
    chk("R3 rising kick restarts", wdFlag, 0);
    doTick(1);
    chk("R3 expiry after rising kick", wdFlag, 1);
    // R3 falling edge restart
    prep();
    doWrite(8'h08);
    doTick(1);
    @(negedge clk) kickIn = 1'b0;
    idle(4);
    doTick(1);
    chk("R3 falling kick restarts", wdFlag, 0);

    // R4 write restart
    prep();
    doWrite(8'h08);
    doTick(1);
    doWrite(8'h08);
    doTick(1);
    chk("R4 write restarts", wdFlag, 0);
    doTick(1);
    chk("R4 expiry after write", wdFlag, 1);
    // R4 write collides with tick
    prep();
    doWrite(8'h04);
    @(negedge clk) begin regWrEn = 1'b1; regWrData = 8'h04; tick16 = 1'b1; end
    @(negedge clk) begin regWrEn = 1'b0; tick16 = 1'b0; end
    chk("R4 write beats tick", wdFlag, 0);

    // R5 flag read clear, R6 irq hold
    doTick(1);
    chk("R6 irq set", irqOut, 1);
    doRead();
    chk("R5 flag cleared by read", wdFlag, 0);
    chk("R6 irq kept after read", irqOut, 1);
    doWrite(8'h04);
    chk("R6 nonzero write keeps irq", irqOut, 1);
    doWrite(8'h00);
    chk("R6 zero write clears irq", irqOut, 0);
    // R5 set wins over simultaneous read
    doWrite(8'h04);
    @(negedge clk) begin tick16 = 1'b1; flagRdEn = 1'b1; end
    @(negedge clk) begin tick16 = 1'b0; flagRdEn = 1'b0; end
    chk("R5 set beats read", wdFlag, 1);

    // R7 R8 steer1 pulse length, wipe, ft strobe
    prep();
    ftSeen = 0;
    doWrite(8'h84);
    doTick(1);
    chk("R8 cfg wiped", cfgOut, 0);
    chk("R7 irq stays low", irqOut, 0);
    chk("R7 reset low", rstOutN, 0);
    idle(3);
    chk("R8 ft strobe once", ftSeen, 1);
    doTick(1);
    chk("R7 reset still low after one tick", rstOutN, 0);
    doTick(1);
    chk("R7 reset released on second tick", rstOutN, 1);
    doRead();
    doTick(40);
    chk("R8 no expiry after wipe", wdFlag, 0);

    // R9 power-down
    prep();
    doWrite(8'h04);
    doTick(1);
    @(negedge clk) pwrDown = 1'b1;
    @(negedge clk);
    chk("R9 irq cleared", irqOut, 0);
    chk("R9 cfg cleared", cfgOut, 0);
    doWrite(8'h0C);
    chk("R9 write ignored", cfgOut, 0);
    @(negedge clk) pwrDown = 1'b0;
    doRead();
    doTick(20);
    chk("R9 disabled after power-down", wdFlag, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule